// File: doc/BRIEF.md
# Privilege Ring Trap Controller

This block sits beside the decode stage of a small processor. It holds the current privilege ring as a two-bit value, where ring 0 is the kernel with full rights and ring 3 is user code. For every decoded instruction it decides whether the instruction may execute. When it does not, or when a trap, a fault or an interrupt arrives, the block takes an event. It records the interrupted PC and ring, drops to ring 0, and sends fetch to a handler address read from a 256-entry vector table. A return-from-trap instruction puts the recorded ring back and sends fetch to the recorded PC.

The kernel programs the vector table and the saved context through privileged instruction classes. In the same cycle as the instruction, it supplies the operand byte and the data word. The saved context is one level deep. After taking an event, the handler must pulse an acknowledge, which tells the block it has stored that context elsewhere. Until then, a nested event is still taken, but it does not overwrite the context.

Top module: `ring_trap_ctrl`

## Requirements
- R1: After synchronous reset, the ring is 0, no grant or redirect is signalled, and the saved PC, saved ring and event vector are all zero.
- R2: The instruction class code is 0 for plain, 1 for I/O, 2 for memory-management, 3 for context-register write, 4 for halt, 5 for vector write, 6 for trap and 7 for return. Codes 1, 2, 3, 4, 5 and 7 are privileged. A valid instruction at ring 0 that raises no event is granted, with the grant shown one cycle later. A plain or trap instruction raises no protection fault at any ring.
- R3: A privileged class at a nonzero ring is not granted. It raises a protection fault on vector 13, saving the instruction's own PC and the current ring, and the ring becomes 0.
- R4: A trap instruction (class 6) takes the event on the vector given in its operand byte. It saves PC+4 and the current ring.
- R5: An external fault or interrupt takes the event on its own vector number. It saves the PC presented that cycle, and any instruction presented that cycle is not granted.
- R6: At most one event is taken per cycle. The priority order is external fault first, then protection fault, then trap, then interrupt.
- R7: A granted return (class 7) sets the ring to the saved ring and redirects to the saved PC. It also clears the unacknowledged state.
- R8: A granted vector write (class 5) stores the data word at the table entry named by the operand byte. At a nonzero ring the write leaves the entry unchanged and raises the protection fault.
- R9: After an event, the saved context is held until acknowledged. Events taken before the acknowledge leave the saved PC and ring unchanged. An acknowledge in the same cycle as an event lets that event save.
- R10: A granted context-register write (class 3) loads the saved PC from the data word and the saved ring from operand bits 1:0.
- R11: All outputs are registered. For each event or granted return, the redirect valid is a single-cycle pulse in the cycle after the cause. The redirect address is the vector-table entry for an event and the saved PC for a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | A decoded instruction is presented |
| instr_class | input | 3 | Instruction class code (see R2) |
| instr_pc | input | PC_W | PC of the presented instruction, or the next PC when none |
| instr_opnd | input | VEC_W | Trap vector, table index or ring operand |
| instr_data | input | PC_W | Data word for vector and context writes |
| fault_req | input | 1 | External fault request |
| fault_vec | input | VEC_W | Vector number of the external fault |
| irq_req | input | 1 | External interrupt request |
| irq_vec | input | VEC_W | Vector number of the interrupt |
| handler_ack | input | 1 | Handler has stored the saved context |
| cur_level | output | 2 | Current privilege ring |
| exec_grant | output | 1 | Previous cycle's instruction may execute |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_pc | output | PC_W | Redirect target |
| event_vec | output | VEC_W | Vector of the most recent event |
| saved_pc | output | PC_W | Saved PC |
| saved_level | output | 2 | Saved ring |

## Verification
Some properties are checked by assertions on every cycle:
- At most one event source is selected.
- Every event leaves the ring at 0.
- A privileged instruction outside ring 0 is never granted and always redirects.
- The saved context stays frozen while unacknowledged.
- A return restores the saved ring.

Other behaviour can only be shown by the bench's scenarios: the table contents that reach the redirect address, the ignored user-ring table write, the PC+4 saved on traps, and the full priority ordering when several sources collide.

// File: rtl/ring_trap_pkg.sv
`timescale 1ns/1ps
package ring_trap_pkg;

  typedef enum logic [2:0] {
    OPC_PLAIN = 3'd0,
    OPC_IO    = 3'd1,
    OPC_MMU   = 3'd2,
    OPC_CSR   = 3'd3,
    OPC_HALT  = 3'd4,
    OPC_VTWR  = 3'd5,
    OPC_TRAP  = 3'd6,
    OPC_RET   = 3'd7
  } opc_e;

  function automatic logic is_priv(input opc_e c);
    return (c != OPC_PLAIN) && (c != OPC_TRAP);
  endfunction

endpackage

// File: rtl/ring_vec_table.sv
`timescale 1ns/1ps
module ring_vec_table #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ring_event_arb.sv
`timescale 1ns/1ps
module ring_event_arb
  import ring_trap_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int VEC_W      = 8,
  parameter int GP_VEC     = 13,
  parameter int INSN_BYTES = 4
) (
  input  logic             instr_valid,
  input  opc_e             opc,
  input  logic [PC_W-1:0]  instr_pc,
  input  logic [VEC_W-1:0] instr_opnd,
  input  logic             fault_req,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             in_kernel,
  output logic             ev_take,
  output logic [VEC_W-1:0] ev_vec,
  output logic [PC_W-1:0]  ev_pc,
  output logic             grant
);
  localparam logic [VEC_W-1:0] GP_CODE  = VEC_W'(GP_VEC);
  localparam logic [PC_W-1:0]  PC_STEP  = PC_W'(INSN_BYTES);

  logic sel_fault, sel_gp, sel_trap, sel_irq;

  always_comb begin
    sel_fault = fault_req;
    sel_gp    = !sel_fault && instr_valid && is_priv(opc) && !in_kernel;
    sel_trap  = !sel_fault && !sel_gp && instr_valid && (opc == OPC_TRAP);
    sel_irq   = !sel_fault && !sel_gp && !sel_trap && irq_req;
    ev_take   = sel_fault || sel_gp || sel_trap || sel_irq;
    grant     = instr_valid && !ev_take;

    ev_vec = irq_vec;
    ev_pc  = instr_pc;
    if (sel_fault) begin
      ev_vec = fault_vec;
    end else if (sel_gp) begin
      ev_vec = GP_CODE;
    end else if (sel_trap) begin
      ev_vec = instr_opnd;
      ev_pc  = instr_pc + PC_STEP;
    end
  end

  // R6
  always_comb begin
    one_event_chk: assert ($onehot0({sel_fault, sel_gp, sel_trap, sel_irq}));
  end
endmodule

// File: rtl/ring_ctx_save.sv
`timescale 1ns/1ps
module ring_ctx_save
  import ring_trap_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int VEC_W = 8,
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_take,
  input  logic [VEC_W-1:0] ev_vec,
  input  logic [PC_W-1:0]  ev_pc,
  input  logic             grant,
  input  opc_e             opc,
  input  logic [LVL_W-1:0] lvl_opnd,
  input  logic [PC_W-1:0]  instr_data,
  input  logic             ack,
  output logic [LVL_W-1:0] level,
  output logic [PC_W-1:0]  saved_pc,
  output logic [LVL_W-1:0] saved_level,
  output logic             exec_grant,
  output logic             redir_valid,
  output logic             ret_sel,
  output logic [PC_W-1:0]  ret_pc,
  output logic [VEC_W-1:0] event_vec
);
  logic busy;
  logic ret_go, csr_go, may_save;

  assign ret_go   = grant && (opc == OPC_RET);
  assign csr_go   = grant && (opc == OPC_CSR);
  assign may_save = !busy || ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      level       <= '0;
      saved_pc    <= '0;
      saved_level <= '0;
      busy        <= 1'b0;
      exec_grant  <= 1'b0;
      redir_valid <= 1'b0;
      ret_sel     <= 1'b0;
      ret_pc      <= '0;
      event_vec   <= '0;
    end else begin
      exec_grant  <= grant;
      redir_valid <= ev_take || ret_go;
      ret_sel     <= ret_go;
      if (ev_take) begin
        level     <= '0;
        event_vec <= ev_vec;
        busy      <= 1'b1;
        if (may_save) begin
          saved_pc    <= ev_pc;
          saved_level <= level;
        end
      end else begin
        if (ack) busy <= 1'b0;
        if (csr_go) begin
          saved_pc    <= instr_data;
          saved_level <= lvl_opnd;
        end
        if (ret_go) begin
          level  <= saved_level;
          ret_pc <= saved_pc;
          busy   <= 1'b0;
        end
      end
    end
  end

  // R3
  event_to_kernel_chk: assert property (@(posedge clk) disable iff (rst)
    ev_take |=> (level == '0));

  // R9
  keep_saved_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_take && busy && !ack) |=> ($stable(saved_pc) && $stable(saved_level)));

  // R7
  ret_restore_chk: assert property (@(posedge clk) disable iff (rst)
    ret_go |=> (level == $past(saved_level)));
endmodule

// File: rtl/ring_trap_ctrl.sv
`timescale 1ns/1ps
module ring_trap_ctrl
  import ring_trap_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int VEC_W      = 8,
  parameter int GP_VEC     = 13,
  parameter int INSN_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [2:0]       instr_class,
  input  logic [PC_W-1:0]  instr_pc,
  input  logic [VEC_W-1:0] instr_opnd,
  input  logic [PC_W-1:0]  instr_data,
  input  logic             fault_req,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             handler_ack,
  output logic [1:0]       cur_level,
  output logic             exec_grant,
  output logic             redir_valid,
  output logic [PC_W-1:0]  redir_pc,
  output logic [VEC_W-1:0] event_vec,
  output logic [PC_W-1:0]  saved_pc,
  output logic [1:0]       saved_level
);
  localparam int LVL_W = 2;

  opc_e             opc;
  logic             ev_take, grant, ret_sel;
  logic [VEC_W-1:0] ev_vec;
  logic [PC_W-1:0]  ev_pc, ret_pc, vt_rdata;
  logic             vt_we;

  assign opc   = opc_e'(instr_class);
  assign vt_we = grant && (opc == OPC_VTWR);

  ring_event_arb #(
    .PC_W(PC_W), .VEC_W(VEC_W), .GP_VEC(GP_VEC), .INSN_BYTES(INSN_BYTES)
  ) u_arb (
    .instr_valid(instr_valid), .opc(opc), .instr_pc(instr_pc),
    .instr_opnd(instr_opnd), .fault_req(fault_req), .fault_vec(fault_vec),
    .irq_req(irq_req), .irq_vec(irq_vec), .in_kernel(cur_level == '0),
    .ev_take(ev_take), .ev_vec(ev_vec), .ev_pc(ev_pc), .grant(grant)
  );

  ring_vec_table #(.DATA_W(PC_W), .ADDR_W(VEC_W)) u_tbl (
    .clk(clk), .we(vt_we), .waddr(instr_opnd), .wdata(instr_data),
    .raddr(ev_vec), .rdata(vt_rdata)
  );

  ring_ctx_save #(.PC_W(PC_W), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_ctx (
    .clk(clk), .rst(rst), .ev_take(ev_take), .ev_vec(ev_vec), .ev_pc(ev_pc),
    .grant(grant), .opc(opc), .lvl_opnd(instr_opnd[LVL_W-1:0]),
    .instr_data(instr_data), .ack(handler_ack), .level(cur_level),
    .saved_pc(saved_pc), .saved_level(saved_level), .exec_grant(exec_grant),
    .redir_valid(redir_valid), .ret_sel(ret_sel), .ret_pc(ret_pc),
    .event_vec(event_vec)
  );

  assign redir_pc = ret_sel ? ret_pc : vt_rdata;

  // R3
  no_priv_in_user_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && is_priv(opc) && (cur_level != '0))
      |=> (!exec_grant && redir_valid && (cur_level == '0)));
endmodule

// File: tb/ring_trap_ctrl_bench.sv
`timescale 1ns/1ps
module ring_trap_ctrl_bench;
  localparam int PC_W = 32;
  localparam int VEC_W = 8;

  localparam bit [2:0] C_PLAIN = 3'd0, C_IO = 3'd1, C_MMU = 3'd2, C_CSR = 3'd3,
                       C_HALT = 3'd4, C_VTWR = 3'd5, C_TRAP = 3'd6, C_RET = 3'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_valid = 1'b0;
  logic [2:0] instr_class = '0;
  logic [PC_W-1:0] instr_pc = '0;
  logic [VEC_W-1:0] instr_opnd = '0;
  logic [PC_W-1:0] instr_data = '0;
  logic fault_req = 1'b0;
  logic [VEC_W-1:0] fault_vec = '0;
  logic irq_req = 1'b0;
  logic [VEC_W-1:0] irq_vec = '0;
  logic handler_ack = 1'b0;
  logic [1:0] cur_level;
  logic exec_grant, redir_valid;
  logic [PC_W-1:0] redir_pc, saved_pc;
  logic [VEC_W-1:0] event_vec;
  logic [1:0] saved_level;

  always #2.5 clk = ~clk;

  ring_trap_ctrl u_ring_trap_ctrl (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_class(instr_class),
    .instr_pc(instr_pc), .instr_opnd(instr_opnd), .instr_data(instr_data),
    .fault_req(fault_req), .fault_vec(fault_vec), .irq_req(irq_req),
    .irq_vec(irq_vec), .handler_ack(handler_ack), .cur_level(cur_level),
    .exec_grant(exec_grant), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .event_vec(event_vec), .saved_pc(saved_pc), .saved_level(saved_level)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  int unsigned m_lvl = 0, m_slvl = 0, m_busy = 0, m_evec = 0;
  longint unsigned m_spc = 0, m_rpc = 0;
  bit m_grant = 0, m_redir = 0, m_rpc_known = 0;
  longint unsigned tbl [int];

  task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "cur_level", cur_level, m_lvl);
    chk(tag, "exec_grant", exec_grant, m_grant);
    chk(tag, "redir_valid", redir_valid, m_redir);
    chk(tag, "event_vec", event_vec, m_evec);
    chk(tag, "saved_pc", saved_pc, m_spc);
    chk(tag, "saved_level", saved_level, m_slvl);
    if (m_redir && m_rpc_known) chk(tag, "redir_pc", redir_pc, m_rpc);
  endtask

  task automatic step(string tag, bit v, bit [2:0] cls, bit [31:0] pc, bit [7:0] op,
                      bit [31:0] dat, bit f, bit [7:0] fv, bit irq, bit [7:0] iv, bit ack);
    bit priv, gp, ev;
    int unsigned vec;
    longint unsigned spc;
    instr_valid = v; instr_class = cls; instr_pc = pc; instr_opnd = op;
    instr_data = dat; fault_req = f; fault_vec = fv; irq_req = irq;
    irq_vec = iv; handler_ack = ack;
    @(posedge clk);
    priv = (cls != C_PLAIN) && (cls != C_TRAP);
    gp = v && priv && (m_lvl != 0);
    ev = 1; vec = 0; spc = pc;
    if (f) vec = fv;
    else if (gp) vec = 13;
    else if (v && cls == C_TRAP) begin vec = op; spc = (pc + 4) & 32'hFFFF_FFFF; end
    else if (irq) vec = iv;
    else ev = 0;
    m_grant = v && !ev;
    m_redir = ev || (m_grant && cls == C_RET);
    if (ev) begin
      if (m_busy == 0 || ack) begin m_spc = spc; m_slvl = m_lvl; end
      m_busy = 1; m_lvl = 0; m_evec = vec;
      m_rpc_known = tbl.exists(vec);
      if (m_rpc_known) m_rpc = tbl[vec];
    end else begin
      if (ack) m_busy = 0;
      if (m_grant && cls == C_VTWR) tbl[op] = dat;
      if (m_grant && cls == C_CSR) begin m_spc = dat; m_slvl = op & 3; end
      if (m_grant && cls == C_RET) begin
        m_rpc = m_spc; m_rpc_known = 1; m_lvl = m_slvl; m_busy = 0;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic ins(string tag, bit [2:0] cls, bit [31:0] pc, bit [7:0] op, bit [31:0] dat);
    step(tag, 1, cls, pc, op, dat, 0, 0, 0, 0, 0);
  endtask
  task automatic idle(string tag);
    step(tag, 0, C_PLAIN, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic ack_ret(string tag, bit [31:0] pc);
    step(tag, 0, C_PLAIN, pc, 0, 0, 0, 0, 0, 0, 1);
    ins(tag, C_RET, pc + 4, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1");
    // R8 / R2: program the table at ring 0
    ins("R8", C_VTWR, 32'h100, 8'd13,  32'h2000);
    ins("R8", C_VTWR, 32'h104, 8'h30,  32'h2300);
    ins("R8", C_VTWR, 32'h108, 8'h80,  32'h2800);
    ins("R8", C_VTWR, 32'h10C, 8'h21,  32'h2210);
    ins("R8", C_VTWR, 32'h110, 8'h0E,  32'h20E0);
    ins("R8", C_VTWR, 32'h114, 8'h40,  32'h2400);
    ins("R2", C_PLAIN, 32'h118, 0, 0);
    ins("R2", C_IO,    32'h11C, 0, 0);
    ins("R2", C_MMU,   32'h120, 0, 0);
    ins("R2", C_HALT,  32'h124, 0, 0);
    // R10: load saved context, R7: drop to user
    ins("R10", C_CSR, 32'h128, 8'd3, 32'h1000);
    ins("R7",  C_RET, 32'h12C, 0, 0);
    ins("R2",  C_PLAIN, 32'h1000, 0, 0);
    ins("R2",  C_TRAP, 32'h1004, 8'h30, 0);
    ack_ret("R7", 32'h2300);
    // R3: privileged op in user ring
    ins("R3", C_IO, 32'h1008, 0, 0);
    idle("R11");
    ack_ret("R7", 32'h2000);
    // R4: system call trap
    ins("R4", C_TRAP, 32'h1008, 8'h80, 0);
    ack_ret("R7", 32'h2800);
    // R5: interrupt kills the presented instruction
    step("R5", 1, C_PLAIN, 32'h100C, 0, 0, 0, 0, 1, 8'h21, 0);
    // R9: nested fault while unacknowledged keeps saved context
    step("R9", 1, C_PLAIN, 32'h2210, 0, 0, 1, 8'h0E, 0, 0, 0);
    step("R9", 0, C_PLAIN, 32'h20E0, 0, 0, 0, 0, 0, 0, 1);
    step("R9", 0, C_PLAIN, 32'h20E4, 0, 0, 0, 0, 1, 8'h21, 0);
    step("R9", 1, C_PLAIN, 32'h2210, 0, 0, 1, 8'h0E, 0, 0, 1);
    step("R9", 0, C_PLAIN, 32'h20E0, 0, 0, 0, 0, 0, 0, 1);
    ins("R10", C_CSR, 32'h20E4, 8'd3, 32'h1100);
    ins("R7",  C_RET, 32'h20E8, 0, 0);
    // R6: priority
    step("R6", 1, C_TRAP, 32'h1100, 8'h30, 0, 1, 8'h0E, 1, 8'h21, 0);
    ack_ret("R6", 32'h20E0);
    step("R6", 1, C_TRAP, 32'h1100, 8'h30, 0, 0, 0, 1, 8'h21, 0);
    ack_ret("R6", 32'h2300);
    step("R6", 1, C_IO, 32'h1104, 0, 0, 0, 0, 1, 8'h21, 0);
    ack_ret("R6", 32'h2000);
    // R8: user-ring table write ignored
    ins("R8", C_VTWR, 32'h1104, 8'h40, 32'hDEAD_BEEF);
    ack_ret("R8", 32'h2000);
    ins("R8", C_TRAP, 32'h1104, 8'h40, 0);
    ack_ret("R8", 32'h2400);
    // R3: return and halt from user ring fault
    ins("R3", C_RET, 32'h1108, 0, 0);
    ack_ret("R3", 32'h2000);
    ins("R3", C_HALT, 32'h1108, 0, 0);
    idle("R11");
    ack_ret("R7", 32'h2000);
    idle("R11");
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule